// File: doc/BRIEF.md
# Push-Button Press Duration Classifier

This block watches an active-low push-button pin and measures how long each press lasts. The pin is first brought into the clock domain through a two-flop synchroniser. A saturating counter then counts the press in units of a slow enable tick, and the count is decoded into single-cycle events. The tick is an input port, normally one pulse per millisecond. A press that releases too early to clear the debounce window is dropped without a trace. A press that stays down long enough produces, in turn:

- a press pulse at the end of the debounce window;
- an activation pulse at a hold time chosen by a two-bit select;
- a forced power-off pulse while the button is still held, when that feature is enabled;
- a power-cycle pulse on release, if the hold reached the power-cycle time.

The power state machine that uses these events sits downstream and is outside this block. All thresholds are parameters given in ticks. The defaults give a 32-tick debounce, activation times of 32, 500, 1000 and 2000 ticks, a 4000-tick power-cycle time and a 6000-tick power-off time.

Top module: `pb_press_classifier`

## Requirements
- R1: While `rst_ni` is low and right after it rises, all four event outputs are 0. The synchroniser treats the pin as released, and the hold counter is zero.
- R2: Let the pin fall just after clock edge p, with a tick on every cycle. Then `press_o` is a one-cycle pulse that goes high after edge p+2+DEBOUNCE_TICKS, provided the pin stays low at least DEBOUNCE_TICKS cycles.
- R3: A press shorter than DEBOUNCE_TICKS ticks produces no event of any kind. A bounce back high restarts the count from zero, so a train of short low pulses is ignored.
- R4: `activate_o` pulses once after edge p+2+T. T is chosen by `act_sel_i`: 2'b00 gives DEBOUNCE_TICKS, 2'b01 gives ACT1_TICKS, 2'b10 gives ACT2_TICKS and 2'b11 gives ACT3_TICKS. A press released before T gives no pulse.
- R5: If the pin rises just after edge e, and the press lasted at least CYCLE_TICKS, then `cycle_o` pulses once after edge e+3. This does not happen when `off_o` already fired during that press, and `cycle_o` and `off_o` are never high together.
- R6: With `off_en_i` high, a press held OFF_TICKS ticks makes `off_o` pulse after edge p+2+OFF_TICKS, while the pin is still low. With `off_en_i` low, `off_o` never fires.
- R7: Each event is one clock wide and fires at most once per press. The counter saturates at OFF_TICKS and returns to zero on release.
- R8: The hold counter advances only on cycles where `tick_i` is high. A press held with no ticks produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pb_ni | input | 1 | Raw button pin, low while pressed |
| tick_i | input | 1 | Timebase enable, one count per high cycle |
| act_sel_i | input | 2 | Activation time select |
| off_en_i | input | 1 | Enables the long-hold power-off event |
| press_o | output | 1 | Debounced press pulse |
| activate_o | output | 1 | Activation hold reached |
| cycle_o | output | 1 | Power-cycle request on release |
| off_o | output | 1 | Power-off request while held |

## Verification
The bench runs with a tick on every cycle, so every result has a fixed latency counted in clock edges:

| Event | Due after edge |
|---|---|
| `press_o` | p+2+DEBOUNCE_TICKS |
| `activate_o` | p+2+T |
| `off_o` | p+2+OFF_TICKS |
| `cycle_o` | e+3, where e is the release edge |

Pins change on the falling clock edge. A monitor samples the outputs a quarter period after each rising edge, and records both the edge index of every pulse and the number of pulses for each event. After each press, the recorded edges and counts are compared with these formulas. The sweep covers every select value, both off-enable settings and hold lengths on each side of every threshold.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    ACT_AT_DEBOUNCE = 2'b00,
    ACT_SHORT       = 2'b01,
    ACT_MEDIUM      = 2'b10,
    ACT_LONG        = 2'b11
  } act_sel_e;
endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], pin_i};
    end
  endgenerate

  assign pin_o = q[STAGES-1];
endmodule

// File: rtl/pb_hold_timer.sv
module pb_hold_timer #(
  parameter int MAX_TICKS = 6000,
  parameter int CNT_W     = $clog2(MAX_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pressed_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_TICKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (!pressed_i)                 cnt_o <= '0;
    else if (tick_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_MAX) else $error("count above ceiling"); // R7
  AST_RELEASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pressed_i |=> cnt_o == '0) else $error("count kept after release"); // R7
  AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pressed_i && !tick_i) |=> $stable(cnt_o)) else $error("count moved without tick"); // R8
endmodule

// File: rtl/pb_event_decode.sv
module pb_event_decode
  import pb_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 32,
  parameter int ACT1_TICKS     = 500,
  parameter int ACT2_TICKS     = 1000,
  parameter int ACT3_TICKS     = 2000,
  parameter int CYCLE_TICKS    = 4000,
  parameter int OFF_TICKS      = 6000,
  parameter int CNT_W          = $clog2(OFF_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pressed_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       act_sel_i,
  input  logic             off_en_i,
  output logic             press_o,
  output logic             activate_o,
  output logic             cycle_o,
  output logic             off_o
);
  localparam logic [CNT_W-1:0] DEB_M1 = CNT_W'(DEBOUNCE_TICKS - 1);
  localparam logic [CNT_W-1:0] A1_M1  = CNT_W'(ACT1_TICKS - 1);
  localparam logic [CNT_W-1:0] A2_M1  = CNT_W'(ACT2_TICKS - 1);
  localparam logic [CNT_W-1:0] A3_M1  = CNT_W'(ACT3_TICKS - 1);
  localparam logic [CNT_W-1:0] OFF_M1 = CNT_W'(OFF_TICKS - 1);
  localparam logic [CNT_W-1:0] CYC_TH = CNT_W'(CYCLE_TICKS);

  act_sel_e         sel;
  logic [CNT_W-1:0] act_m1;
  logic             step;
  logic             hit_deb, hit_act, hit_off;
  logic             off_fired;

  assign sel  = act_sel_e'(act_sel_i);
  assign step = pressed_i && tick_i;

  always_comb begin
    unique case (sel)
      ACT_AT_DEBOUNCE: act_m1 = DEB_M1;
      ACT_SHORT:       act_m1 = A1_M1;
      ACT_MEDIUM:      act_m1 = A2_M1;
      default:         act_m1 = A3_M1;
    endcase
  end

  // a threshold is crossed on the tick that moves the count from N-1 to N
  assign hit_deb = step && cnt_i == DEB_M1;
  assign hit_act = step && cnt_i == act_m1;
  assign hit_off = step && cnt_i == OFF_M1 && off_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      press_o    <= 1'b0;
      activate_o <= 1'b0;
      off_o      <= 1'b0;
      cycle_o    <= 1'b0;
      off_fired  <= 1'b0;
    end else begin
      press_o    <= hit_deb;
      activate_o <= hit_act;
      off_o      <= hit_off;
      cycle_o    <= !pressed_i && cnt_i >= CYC_TH && !off_fired;
      if (!pressed_i)   off_fired <= 1'b0;
      else if (hit_off) off_fired <= 1'b1;
    end
  end

  AST_PRESS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o) else $error("press pulse too wide"); // R7
  AST_ACT_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activate_o |-> $past(pressed_i)) else $error("activation without press"); // R4
  AST_OFF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_o |-> $past(off_en_i) && $past(pressed_i)) else $error("off while disabled"); // R6
  AST_CYCLE_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_o |-> $past(!pressed_i)) else $error("cycle while held"); // R5
  AST_CYCLE_OFF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cycle_o && off_o)) else $error("cycle and off together"); // R5
endmodule

// File: rtl/pb_press_classifier.sv
module pb_press_classifier #(
  parameter int DEBOUNCE_TICKS = 32,
  parameter int ACT1_TICKS     = 500,
  parameter int ACT2_TICKS     = 1000,
  parameter int ACT3_TICKS     = 2000,
  parameter int CYCLE_TICKS    = 4000,
  parameter int OFF_TICKS      = 6000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pb_ni,
  input  logic       tick_i,
  input  logic [1:0] act_sel_i,
  input  logic       off_en_i,
  output logic       press_o,
  output logic       activate_o,
  output logic       cycle_o,
  output logic       off_o
);
  localparam int CNT_W = $clog2(OFF_TICKS + 1);

  logic             pin_s;
  logic             pressed;
  logic [CNT_W-1:0] cnt;

  pb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pb_ni),
    .pin_o (pin_s)
  );

  assign pressed = !pin_s;

  pb_hold_timer #(.MAX_TICKS(OFF_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pressed_i(pressed),
    .tick_i   (tick_i),
    .cnt_o    (cnt)
  );

  pb_event_decode #(
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .ACT1_TICKS    (ACT1_TICKS),
    .ACT2_TICKS    (ACT2_TICKS),
    .ACT3_TICKS    (ACT3_TICKS),
    .CYCLE_TICKS   (CYCLE_TICKS),
    .OFF_TICKS     (OFF_TICKS),
    .CNT_W         (CNT_W)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pressed_i (pressed),
    .tick_i    (tick_i),
    .cnt_i     (cnt),
    .act_sel_i (act_sel_i),
    .off_en_i  (off_en_i),
    .press_o   (press_o),
    .activate_o(activate_o),
    .cycle_o   (cycle_o),
    .off_o     (off_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> !(press_o || activate_o || cycle_o || off_o)) else $error("event out of reset"); // R1
endmodule

// File: tb/tb_pb_press_classifier.sv
module tb_pb_press_classifier;
  localparam int CLK_T = 10;
  localparam int DB  = 4;
  localparam int A1  = 8;
  localparam int A2  = 12;
  localparam int A3  = 16;
  localparam int CYC = 20;
  localparam int OFF = 28;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pb_ni = 1'b1;
  logic tick_i = 1'b1;
  logic [1:0] act_sel_i = 2'b00;
  logic off_en_i = 1'b0;
  logic press_o, activate_o, cycle_o, off_o;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int n_pr, n_ac, n_cy, n_of;
  int t_pr, t_ac, t_cy, t_of;

  pb_press_classifier #(
    .DEBOUNCE_TICKS(DB), .ACT1_TICKS(A1), .ACT2_TICKS(A2), .ACT3_TICKS(A3),
    .CYCLE_TICKS(CYC), .OFF_TICKS(OFF), .SYNC_STAGES(2)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pb_ni(pb_ni), .tick_i(tick_i),
    .act_sel_i(act_sel_i), .off_en_i(off_en_i),
    .press_o(press_o), .activate_o(activate_o), .cycle_o(cycle_o), .off_o(off_o)
  );

  always #(CLK_T/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(posedge clk_i) begin
    #(CLK_T/4);
    if (press_o)    begin if (n_pr == 0) t_pr = cyc; n_pr++; end
    if (activate_o) begin if (n_ac == 0) t_ac = cyc; n_ac++; end
    if (cycle_o)    begin if (n_cy == 0) t_cy = cyc; n_cy++; end
    if (off_o)      begin if (n_of == 0) t_of = cyc; n_of++; end
  end

  task automatic clear_rec();
    n_pr = 0; n_ac = 0; n_cy = 0; n_of = 0;
    t_pr = -1; t_ac = -1; t_cy = -1; t_of = -1;
  endtask

  task automatic check_evt(string req, string name, int n, int t, bit fire, int t_exp);
    bit ok;
    n_chk++;
    ok = fire ? (n == 1 && t == t_exp) : (n == 0);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: count=%0d edge=%0d expected count=%0d edge=%0d",
               req, name, n, t, fire ? 1 : 0, fire ? t_exp : -1);
    end
  endtask

  function automatic int act_ticks(int sel);
    case (sel)
      0: return DB;
      1: return A1;
      2: return A2;
      default: return A3;
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // press held for h cycles with tick on every cycle; expected edges from the requirements
  task automatic run_press(int h, int sel, bit en);
    int p, e, at;
    bit off_fire;
    @(negedge clk_i);
    act_sel_i = sel[1:0];
    off_en_i  = en;
    clear_rec();
    p = cyc;
    pb_ni = 1'b0;
    repeat (h) @(negedge clk_i);
    e = cyc;
    pb_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    at = act_ticks(sel);
    off_fire = en && h >= OFF;
    check_evt(h >= DB ? "R2/R7" : "R3", "press", n_pr, t_pr, h >= DB, p + 2 + DB);
    check_evt("R4", "activate", n_ac, t_ac, h >= at, p + 2 + at);
    check_evt("R6", "off", n_of, t_of, off_fire, p + 2 + OFF);
    check_evt("R5", "cycle", n_cy, t_cy, h >= CYC && !off_fire, e + 3);
  endtask

  initial begin
    #(CLK_T * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    int holds[11] = '{1, 3, 4, 8, 12, 16, 19, 20, 27, 28, 33};
    clear_rec();
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet in and just after reset
    check_evt("R1", "press", int'(press_o), -1, 0, 0);
    check_evt("R1", "off", int'(off_o) + int'(cycle_o) + int'(activate_o), -1, 0, 0);
    rst_ni = 1'b1;
    clear_rec();
    repeat (4) @(negedge clk_i);
    check_evt("R1", "any", n_pr + n_ac + n_cy + n_of, -1, 0, 0);

    for (int s = 0; s < 4; s++)
      for (int en = 0; en < 2; en++)
        for (int k = 0; k < 11; k++)
          run_press(holds[k], s, en[0]);

    // R3: bouncing contact, every low stretch shorter than the debounce window
    @(negedge clk_i);
    act_sel_i = 2'b00; off_en_i = 1'b1;
    clear_rec();
    for (int b = 0; b < 5; b++) begin
      pb_ni = 1'b0; repeat (DB - 1) @(negedge clk_i);
      pb_ni = 1'b1; @(negedge clk_i);
    end
    repeat (8) @(negedge clk_i);
    check_evt("R3", "bounce", n_pr + n_ac + n_cy + n_of, -1, 0, 0);

    // R8: long hold with the tick stopped produces nothing
    clear_rec();
    tick_i = 1'b0;
    pb_ni = 1'b0; repeat (OFF + 10) @(negedge clk_i);
    pb_ni = 1'b1; repeat (8) @(negedge clk_i);
    tick_i = 1'b1;
    check_evt("R8", "no_tick", n_pr + n_ac + n_cy + n_of, -1, 0, 0);

    finish_run();
  end
endmodule